// File: doc/BRIEF.md
# Addressed Fixed-Length Message Framer

This block sits between an application and a byte-level radio link. It sends and receives fixed-length messages. Each message carries a destination node address, a handler number and a payload of fixed size. On the send side, the application offers a whole message in one cycle. The block accepts or refuses the request at once. It then hands the message to the byte layer one byte at a time. Each byte waits until the byte layer reports the previous one finished. Once the final byte is finished, the block reports packet completion and then send completion.

On the receive side, the byte layer pushes bytes up as they arrive. It marks the first byte of each frame with a start flag. The block collects a full message and compares its address byte with the node's own address. It also treats the all-ones address as broadcast. Matching messages are offered to the application with their handler number and payload. Messages that do not match, and frames cut short, are dropped without any indication.

Top module: `am_packet_layer`

## Requirements
- R1: A message is MSG_LEN bytes long (default 30). Byte 0 is the destination address and byte 1 is the handler number. Payload byte j (bits [8j+7:8j] of the payload port) is message byte j+2. Bytes go onto the link in increasing byte order.
- R2: A transmit byte is shown with `txb_valid` and is held stable until `txb_ready` is seen. The next byte is not shown until a `txb_done` pulse arrives after that handshake.
- R3: In the same cycle as `send_valid`, `send_ack` is high if the block is idle and `send_nak` is high if it is busy. A refused request has no effect on the message in flight.
- R4: `txb_done` for the last byte makes `pkt_done` high for exactly the next cycle. `send_done` with `send_ok` high follows for exactly one cycle, after which the block is idle.
- R5: A received byte with `rxb_sof` high always begins a new frame as its byte 0. Any partial frame is discarded.
- R6: Received bytes without `rxb_sof` are ignored while no frame is in progress, including bytes after a frame's last byte.
- R7: The cycle after the MSG_LEN-th byte of a frame is received, `rcv_valid` rises if the address byte equals `node_addr` or 8'hFF. `rcv_hid` and `rcv_payload` then carry bytes 1 and 2.. in the R1 layout.
- R8: A complete frame whose address byte is neither `node_addr` nor 8'hFF produces no output.
- R9: `rcv_valid` and its data stay stable until `rcv_ready` is high. A frame completing while an unaccepted message is held is dropped.
- R10: During and after synchronous active-high reset, all valid, done and status outputs are low and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | 8 | This node's address |
| send_valid | input | 1 | Send request |
| send_dest | input | 8 | Destination address of the request |
| send_hid | input | 8 | Handler number of the request |
| send_payload | input | 8*(MSG_LEN-2) | Payload of the request |
| send_ack | output | 1 | Request taken (same cycle) |
| send_nak | output | 1 | Request refused, busy (same cycle) |
| txb_valid | output | 1 | Transmit byte present |
| txb_data | output | 8 | Transmit byte |
| txb_ready | input | 1 | Byte layer takes the byte |
| txb_done | input | 1 | Byte layer finished the taken byte |
| pkt_done | output | 1 | Last byte finished pulse |
| send_done | output | 1 | Send completion pulse |
| send_ok | output | 1 | Success flag, valid with send_done |
| rxb_valid | input | 1 | Received byte present |
| rxb_sof | input | 1 | Received byte starts a frame |
| rxb_data | input | 8 | Received byte |
| rcv_valid | output | 1 | Received message available |
| rcv_ready | input | 1 | Application takes the message |
| rcv_hid | output | 8 | Received handler number |
| rcv_payload | output | 8*(MSG_LEN-2) | Received payload |

## Verification
`send_ack` and `send_nak` depend only on the current request and the idle state, so they are due in the same cycle as `send_valid`. `txb_valid` drops one cycle after a handshake. `pkt_done` follows the last `txb_done` by one cycle and `send_done` follows one cycle later. `rcv_valid` is due one cycle after the last received byte. The bench drives inputs on the falling edge and keeps a behavioural model in queues, which it advances at each rising edge. It compares every output against that model shortly after each falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/am_pkg.sv
package am_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] BCAST_ADDR = 8'hFF;

    typedef logic [BYTE_W-1:0] am_byte_t;

    typedef struct packed {
        am_byte_t dest;
        am_byte_t hid;
    } am_hdr_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SHOW,
        TX_WAIT,
        TX_PKT,
        TX_FIN
    } tx_state_e;

    function automatic logic addr_hit(am_byte_t addr, am_byte_t node);
        return (addr == node) || (addr == BCAST_ADDR);
    endfunction
endpackage

// File: rtl/am_tx_framer.sv
module am_tx_framer
    import am_pkg::*;
#(
    parameter int MSG_LEN = 30,
    localparam int PAY_W = BYTE_W * (MSG_LEN - 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  am_hdr_t          req_hdr,
    input  logic [PAY_W-1:0] req_payload,
    output logic             req_ack,
    output logic             req_nak,
    output logic             byte_valid,
    output am_byte_t         byte_data,
    input  logic             byte_ready,
    input  logic             byte_done,
    output logic             frame_done,
    output logic             msg_done,
    output logic             msg_ok
);
    localparam int CNT_W = $clog2(MSG_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_LEN - 1);

    tx_state_e        state;
    am_byte_t         shreg [MSG_LEN];
    logic [CNT_W-1:0] sent;

    wire idle = (state == TX_IDLE);

    assign req_ack    = req_valid && idle;
    assign req_nak    = req_valid && !idle;
    assign byte_valid = (state == TX_SHOW);
    assign byte_data  = shreg[0];
    assign frame_done = (state == TX_PKT);
    assign msg_done   = (state == TX_FIN);
    assign msg_ok     = (state == TX_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            sent  <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (req_valid) begin
                    state <= TX_SHOW;
                    sent  <= '0;
                end
                TX_SHOW: if (byte_ready) state <= TX_WAIT;
                TX_WAIT: if (byte_done) begin
                    if (sent == LAST_IDX) begin
                        state <= TX_PKT;
                    end else begin
                        state <= TX_SHOW;
                        sent  <= sent + 1'b1;
                    end
                end
                TX_PKT:  state <= TX_FIN;
                TX_FIN:  state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (idle && req_valid) begin
            shreg[0] <= req_hdr.dest;
            shreg[1] <= req_hdr.hid;
            for (int k = 0; k < MSG_LEN - 2; k++) begin
                shreg[k+2] <= req_payload[BYTE_W*k +: BYTE_W];
            end
        end else if (byte_valid && byte_ready) begin
            for (int k = 0; k < MSG_LEN - 1; k++) begin
                shreg[k] <= shreg[k+1];
            end
            shreg[MSG_LEN-1] <= '0;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data)) else $error("AST_TX_HOLD"); // R2
    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready |=> !byte_valid) else $error("AST_TX_DROP"); // R2
    AST_PKT_THEN_FIN: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> msg_done && !frame_done) else $error("AST_PKT_THEN_FIN"); // R4
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack) else $error("AST_ONE_ACK"); // R3
    AST_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_valid, frame_done, msg_done})) else $error("AST_EXCL"); // R4
endmodule

// File: rtl/am_rx_deframer.sv
module am_rx_deframer
    import am_pkg::*;
#(
    parameter int MSG_LEN = 30,
    localparam int PAY_W = BYTE_W * (MSG_LEN - 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  am_byte_t         node_addr,
    input  logic             in_valid,
    input  logic             in_sof,
    input  am_byte_t         in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output am_byte_t         out_hid,
    output logic [PAY_W-1:0] out_payload
);
    localparam int CNT_W = $clog2(MSG_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_LEN - 1);

    am_byte_t         asm_buf [MSG_LEN-1];
    logic [CNT_W-1:0] idx;
    logic             active;
    logic [PAY_W-1:0] pay_next;

    wire complete = in_valid && !in_sof && active && (idx == LAST_IDX);
    wire slot_free = !out_valid || out_ready;

    for (genvar j = 0; j < MSG_LEN - 3; j++) begin : g_pay
        assign pay_next[BYTE_W*j +: BYTE_W] = asm_buf[j+2];
    end
    assign pay_next[PAY_W-1 -: BYTE_W] = in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (in_valid) begin
            if (in_sof) begin
                active <= 1'b1;
                idx    <= CNT_W'(1);
            end else if (active) begin
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                    idx    <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_sof) begin
            asm_buf[0] <= in_data;
        end else if (in_valid && active && idx != LAST_IDX) begin
            asm_buf[idx] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_hid     <= '0;
            out_payload <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (complete && slot_free && addr_hit(asm_buf[0], node_addr)) begin
                out_valid   <= 1'b1;
                out_hid     <= asm_buf[1];
                out_payload <= pay_next;
            end
        end
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_hid) && $stable(out_payload)) else $error("AST_RX_HOLD"); // R9
    AST_RX_IDLE_IGN: assert property (@(posedge clk) disable iff (rst)
        !active && !(in_valid && in_sof) |=> !active) else $error("AST_RX_IDLE_IGN"); // R6
    AST_RX_SOF: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sof |=> active && !$rose(out_valid)) else $error("AST_RX_SOF"); // R5
endmodule

// File: rtl/am_packet_layer.sv
module am_packet_layer
    import am_pkg::*;
#(
    parameter int MSG_LEN = 30,
    localparam int PAY_W = 8 * (MSG_LEN - 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       node_addr,
    input  logic             send_valid,
    input  logic [7:0]       send_dest,
    input  logic [7:0]       send_hid,
    input  logic [PAY_W-1:0] send_payload,
    output logic             send_ack,
    output logic             send_nak,
    output logic             txb_valid,
    output logic [7:0]       txb_data,
    input  logic             txb_ready,
    input  logic             txb_done,
    output logic             pkt_done,
    output logic             send_done,
    output logic             send_ok,
    input  logic             rxb_valid,
    input  logic             rxb_sof,
    input  logic [7:0]       rxb_data,
    output logic             rcv_valid,
    input  logic             rcv_ready,
    output logic [7:0]       rcv_hid,
    output logic [PAY_W-1:0] rcv_payload
);
    am_hdr_t hdr;
    assign hdr.dest = send_dest;
    assign hdr.hid  = send_hid;

    am_tx_framer #(.MSG_LEN(MSG_LEN)) tx_i (
        .clk(clk), .rst(rst),
        .req_valid(send_valid), .req_hdr(hdr), .req_payload(send_payload),
        .req_ack(send_ack), .req_nak(send_nak),
        .byte_valid(txb_valid), .byte_data(txb_data),
        .byte_ready(txb_ready), .byte_done(txb_done),
        .frame_done(pkt_done), .msg_done(send_done), .msg_ok(send_ok)
    );

    am_rx_deframer #(.MSG_LEN(MSG_LEN)) rx_i (
        .clk(clk), .rst(rst), .node_addr(node_addr),
        .in_valid(rxb_valid), .in_sof(rxb_sof), .in_data(rxb_data),
        .out_valid(rcv_valid), .out_ready(rcv_ready),
        .out_hid(rcv_hid), .out_payload(rcv_payload)
    );

    AST_NO_DOUBLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !(send_ack && send_nak)) else $error("AST_NO_DOUBLE_STATUS"); // R3
endmodule

// File: tb/am_packet_layer_tb.sv
`timescale 1ns/100ps
module am_packet_layer_tb_top;
    localparam int LEN = 30;
    localparam int PW  = 8 * (LEN - 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] node_addr = 8'h21;
    logic send_valid = 1'b0;
    logic [7:0] send_dest = '0, send_hid = '0;
    logic [PW-1:0] send_payload = '0;
    logic send_ack, send_nak, txb_valid, pkt_done, send_done, send_ok;
    logic [7:0] txb_data;
    logic txb_ready = 1'b0, txb_done = 1'b0;
    logic rxb_valid = 1'b0, rxb_sof = 1'b0;
    logic [7:0] rxb_data = '0;
    logic rcv_valid, rcv_ready = 1'b1;
    logic [7:0] rcv_hid;
    logic [PW-1:0] rcv_payload;

    always #2.5 clk = ~clk;

    am_packet_layer #(.MSG_LEN(LEN)) dut_i (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pb(int seed, int j);
        return 8'((seed * 37 + j * 13 + 5) & 8'hFF);
    endfunction

    function automatic logic [PW-1:0] mkpay(int seed);
        logic [PW-1:0] p;
        for (int j = 0; j < LEN - 2; j++) p[8*j +: 8] = pb(seed, j);
        return p;
    endfunction

    // behavioural reference model
    int m_st = 0;               // 0 idle 1 showing 2 waiting 3 pkt 4 fin
    logic [7:0] m_q[$];
    logic [7:0] m_rb[$];
    bit m_act = 0, m_rv = 0;
    logic [7:0] m_hid = '0;
    logic [PW-1:0] m_pay = '0;
    bit pend = 0;
    int dcnt = 0, hs = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_q = {}; m_rb = {}; m_act = 0; m_rv = 0; pend = 0;
        end else begin
            case (m_st)
                0: if (send_valid) begin
                    m_q = {};
                    m_q.push_back(send_dest);   // R1 byte 0
                    m_q.push_back(send_hid);    // R1 byte 1
                    for (int j = 0; j < LEN - 2; j++) m_q.push_back(send_payload[8*j +: 8]);
                    m_st = 1;
                end
                1: if (txb_ready) begin
                    void'(m_q.pop_front());
                    m_st = 2; pend = 1; dcnt = hs % 3; hs++;
                end
                2: if (txb_done) m_st = (m_q.size() == 0) ? 3 : 1;
                3: m_st = 4;
                default: m_st = 0;
            endcase
            if (m_rv && rcv_ready) m_rv = 0;
            if (rxb_valid) begin
                if (rxb_sof) begin
                    m_rb = {}; m_rb.push_back(rxb_data); m_act = 1;
                end else if (m_act) begin
                    m_rb.push_back(rxb_data);
                    if (m_rb.size() == LEN) begin
                        m_act = 0;
                        if ((m_rb[0] == node_addr || m_rb[0] == 8'hFF) && !m_rv) begin
                            m_rv = 1; m_hid = m_rb[1];
                            for (int j = 0; j < LEN - 2; j++) m_pay[8*j +: 8] = m_rb[j+2];
                        end
                        m_rb = {};
                    end
                end
            end
        end
    end

    // byte-layer responder
    always @(negedge clk) begin
        txb_ready <= (cyc % 4) != 1;
        txb_done  <= 1'b0;
        if (pend) begin
            if (dcnt == 0) begin txb_done <= 1'b1; pend = 0; end
            else dcnt--;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        #1;
        if (rst) begin
            chk("R10", "txb_valid", PW'(txb_valid), '0);
            chk("R10", "rcv_valid", PW'(rcv_valid), '0);
            chk("R10", "done", PW'({pkt_done, send_done, send_ok}), '0);
        end else begin
            chk("R3", "send_ack", PW'(send_ack), PW'(send_valid && m_st == 0));
            chk("R3", "send_nak", PW'(send_nak), PW'(send_valid && m_st != 0));
            chk("R2", "txb_valid", PW'(txb_valid), PW'(m_st == 1));
            if (m_st == 1) chk("R1", "txb_data", PW'(txb_data), PW'(m_q[0]));
            chk("R4", "pkt_done", PW'(pkt_done), PW'(m_st == 3));
            chk("R4", "send_done", PW'(send_done), PW'(m_st == 4));
            chk("R4", "send_ok", PW'(send_ok), PW'(m_st == 4));
            chk("R7", "rcv_valid", PW'(rcv_valid), PW'(m_rv));
            if (m_rv) begin
                chk("R7", "rcv_hid", PW'(rcv_hid), PW'(m_hid));
                chk("R9", "rcv_payload", rcv_payload, m_pay);
            end
        end
    end

    task automatic do_send(logic [7:0] d, logic [7:0] h, int seed);
        @(negedge clk);
        send_valid = 1; send_dest = d; send_hid = h; send_payload = mkpay(seed);
        @(negedge clk);
        send_valid = 0;
    endtask

    task automatic do_rx(logic [7:0] a, logic [7:0] h, int seed, int nb, int gap, bit sof1);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rxb_valid = 1; rxb_sof = sof1 && (i == 0);
            rxb_data = (i == 0) ? a : (i == 1) ? h : pb(seed, i - 2);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                rxb_valid = 0; rxb_sof = 0;
            end
        end
        @(negedge clk);
        rxb_valid = 0; rxb_sof = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        fork
            begin : tx_thread
                do_send(8'h21, 8'h05, 1);          // R1 R2 R4
                repeat (6) @(negedge clk);
                do_send(8'h77, 8'h66, 9);          // R3 refused while busy
                while (m_st != 0) @(negedge clk);
                do_send(8'hFF, 8'h09, 2);
                while (m_st != 0) @(negedge clk);
                repeat (3) @(negedge clk);
            end
            begin : rx_thread
                do_rx(8'h21, 8'h11, 3, LEN, 0, 1);  // R7 match
                do_rx(8'hFF, 8'h12, 4, LEN, 1, 1);  // R7 broadcast
                do_rx(8'h33, 8'h13, 5, LEN, 0, 1);  // R8 mismatch
                do_rx(8'h21, 8'h14, 6, 10, 0, 1);   // R5 truncated
                do_rx(8'h21, 8'h15, 7, LEN, 0, 1);  // R5 restart
                do_rx(8'h21, 8'h16, 8, 5, 0, 0);    // R6 stray bytes
                rcv_ready = 0;
                do_rx(8'h21, 8'h17, 10, LEN, 0, 1); // R9 held
                do_rx(8'h21, 8'h18, 11, LEN, 0, 1); // R9 dropped
                repeat (4) @(negedge clk);
                rcv_ready = 1;
                repeat (2) @(negedge clk);
                do_rx(8'h21, 8'h19, 12, LEN, 0, 1); // R7 after release
            end
        join
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule